// File: doc/BRIEF.md
# Latched Serial Tuning-Word Receiver

This block is the receiving end of a three-wire control port for a digitally tuned component. A controller raises an active-high enable, clocks data bits in on the serial clock line, and then lowers the enable. The block samples each data bit on a rising serial clock. It keeps only the most recent eight bits and never counts them. It commits the word to its outputs only when the enable falls.

The serial lines are asynchronous to the block's fast system clock. Clock, enable and data each pass through a synchroniser, and the block finds edges by comparing each synchronised value with its previous one. A control module turns those edges into a small set of strobes. A datapath module holds the shift register and the committed outputs.

A committed word is split into three fields. The upper two bits must be zero. The next bit selects standby. The low five bits are the tuning state.

Top module: `tune_ctl_rx`

## Requirements
- R1: After reset, `tuneState` is 0, `standbyOut` is 0, `rsvdErr` is 0 and the internal shift register is all zeros.
- R2: Bits shift in most significant bit first. The bit sampled on the first rising serial clock of an eight-clock transfer lands in word bit 7.
- R3: The outputs keep their previous values throughout a transfer. They change only after the enable falls.
- R4: When more than eight rising serial clocks occur in one transfer, only the last eight bits received are committed.
- R5: The shift register is not cleared when the enable rises. After a transfer of fewer than eight clocks, the committed word is the previous contents shifted left by the number of new bits, with the new bits in the low positions.
- R6: Rising serial clocks that occur while the enable is low do not change the shift register. A following transfer with no clocks commits the unchanged word.
- R7: Word bit 5 drives `standbyOut`. A value of 1 means low-current standby and 0 means active.
- R8: Word bits 4..0 drive `tuneState`, from 00000 to 11111 (32 states).
- R9: A committed word with bit 7 or bit 6 set raises `rsvdErr`, which stays high until reset. The state and standby fields are still updated from that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; data is sampled on its rising edge |
| serData | input | 1 | Serial data, most significant bit first |
| serEn | input | 1 | Active-high transfer enable; the word is committed on its falling edge |
| tuneState | output | 5 | Committed tuning state |
| standbyOut | output | 1 | Committed standby selection |
| rsvdErr | output | 1 | Sticky flag: a reserved bit was set in a committed word |

## Verification
The assertions check several properties on every cycle:
- the committed outputs hold steady whenever no commit strobe is present;
- the error flag never falls without a reset, and it only rises one cycle after a commit;
- each shift places the synchronised data bit in the lowest position;
- the commit and shift strobes last exactly one cycle.

Only the bench's scenarios can show the following. It sweeps every one of the 256 words and tracks the expected outputs with its own shadow model. It also checks three cases: transfers with more or fewer than eight clocks, clocks that arrive while the enable is low, and word ordering.

// File: rtl/tune_ctl_rx_pkg.sv
package tune_ctl_rx_pkg;
  localparam int WORD_W  = 8;
  localparam int STATE_W = 5;
  localparam int SBY_POS = STATE_W;
  localparam int RSV_LO  = STATE_W + 1;

  typedef struct packed {
    logic shiftEn;
    logic commitEn;
    logic dataBit;
  } rx_strobe_t;
endpackage

// File: rtl/tune_rx_ctrl.sv
module tune_rx_ctrl
  import tune_ctl_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serEn,
  output rx_strobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES:0]   enPipe;
  logic [SYNC_STAGES-1:0] datPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      enPipe  <= '0;
      datPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-1:0], serClk};
      enPipe  <= {enPipe[SYNC_STAGES-1:0], serEn};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
    end
  end

  logic clkRise, enFall, enLevel;
  assign clkRise = clkPipe[LAST] && !clkPipe[SYNC_STAGES];
  assign enFall  = !enPipe[LAST] && enPipe[SYNC_STAGES];
  assign enLevel = enPipe[LAST];

  always_comb begin
    strobe.shiftEn  = clkRise && enLevel;
    strobe.commitEn = enFall;
    strobe.dataBit  = datPipe[LAST];
  end

  // R3
  commit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitEn |=> !strobe.commitEn);
  // R6
  shift_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);
endmodule

// File: rtl/tune_rx_data.sv
module tune_rx_data
  import tune_ctl_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  rx_strobe_t         strobe,
  output logic [STATE_W-1:0] tuneState,
  output logic               standbyOut,
  output logic               rsvdErr
);
  logic [WORD_W-1:0] shiftReg;
  logic              rsvdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strobe.dataBit};
  end

  assign rsvdHit = |shiftReg[WORD_W-1:RSV_LO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tuneState  <= '0;
      standbyOut <= 1'b0;
      rsvdErr    <= 1'b0;
    end else if (strobe.commitEn) begin
      tuneState  <= shiftReg[STATE_W-1:0];
      standbyOut <= shiftReg[SBY_POS];
      rsvdErr    <= rsvdErr | rsvdHit;
    end
  end

  // R3
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitEn |=> ($stable(tuneState) && $stable(standbyOut)));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsvdErr |=> rsvdErr);
  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rsvdErr) |-> $past(strobe.commitEn));
  // R2
  shift_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> shiftReg[0] == $past(strobe.dataBit));
endmodule

// File: rtl/tune_ctl_rx.sv
module tune_ctl_rx
  import tune_ctl_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serEn,
  output logic [STATE_W-1:0] tuneState,
  output logic               standbyOut,
  output logic               rsvdErr
);
  rx_strobe_t strobe;

  tune_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEn(serEn), .strobe(strobe)
  );

  tune_rx_data data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tuneState(tuneState),
    .standbyOut(standbyOut), .rsvdErr(rsvdErr)
  );
endmodule

// File: tb/tune_ctl_rx_tb_top.sv
module tune_ctl_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serEn = 1'b0;
  logic [4:0] tuneState;
  logic standbyOut, rsvdErr;

  int applied = 0;
  int failed = 0;
  logic [7:0] model = '0;
  logic [4:0] expState = '0;
  logic expSby = 1'b0;
  logic expErr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tune_ctl_rx dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEn(serEn), .tuneState(tuneState), .standbyOut(standbyOut),
    .rsvdErr(rsvdErr)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    applied++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic checkOuts(input string tag);
    check(tag, {tuneState}, {3'b0, expState});
    check(tag, {7'b0, standbyOut}, {7'b0, expSby});
    check(tag, {7'b0, rsvdErr}, {7'b0, expErr});
  endtask

  task automatic clockBit(input logic b);
    serData = b;
    waitCyc(HALF_BIT);
    serClk = 1'b1;
    waitCyc(HALF_BIT);
    serClk = 1'b0;
    if (serEn) model = {model[6:0], b};
  endtask

  task automatic doReset();
    rstN = 1'b0;
    serEn = 1'b0; serClk = 1'b0; serData = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    model = '0; expState = '0; expSby = 1'b0; expErr = 1'b0;
    waitCyc(2);
  endtask

  // Sends n bits of val (msb of the n first); optionally checks the held outputs mid-frame (R3).
  task automatic sendFrame(input logic [15:0] val, input int n, input bit midCheck);
    serEn = 1'b1;
    waitCyc(HALF_BIT);
    for (int i = n - 1; i >= 0; i--) clockBit(val[i]);
    waitCyc(HALF_BIT);
    if (midCheck) checkOuts("R3 hold during transfer");
    serEn = 1'b0;
    waitCyc(6);
    expState = model[4:0];
    expSby   = model[5];
    expErr   = expErr | model[7] | model[6];
  endtask

  initial begin
    doReset();
    // R1
    checkOuts("R1 reset");

    // R8 R7 R9 R2: exhaustive sweep of every word
    for (int w = 0; w < 256; w++) begin
      sendFrame(16'(w), 8, (w % 37) == 5);
      checkOuts("R2 R7 R8 R9 sweep");
    end

    doReset();
    checkOuts("R1 second reset");

    // R2: ordering, first bit lands in bit 7 of an eight-clock word
    sendFrame(16'h0001, 8, 1'b0);
    check("R2 lsb", {3'b0, tuneState}, 8'h01);
    sendFrame(16'h0010, 8, 1'b0);
    check("R2 ordering", {3'b0, tuneState}, 8'h10);

    // R4: twelve clocks, last eight kept
    sendFrame(16'h0F2A, 12, 1'b1);
    checkOuts("R4 overlong");
    check("R4 state", {3'b0, tuneState}, 8'h0A);

    // R5: three clocks shift onto retained contents
    sendFrame(16'h0003, 3, 1'b0);
    checkOuts("R5 short frame");

    // R6: serial clocks while enable low are ignored
    for (int i = 0; i < 5; i++) clockBit(1'b1);
    sendFrame(16'h0000, 0, 1'b0);
    checkOuts("R6 idle clocks");

    // R9: reserved bit sets error, fields still update, and it sticks
    sendFrame(16'h0095, 8, 1'b0);
    checkOuts("R9 reserved set");
    check("R9 err", {7'b0, rsvdErr}, 8'h01);
    sendFrame(16'h0027, 8, 1'b0);
    checkOuts("R9 sticky");
    check("R7 standby", {7'b0, standbyOut}, 8'h01);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule